// File: doc/BRIEF.md
# Clock-Qualified Reset Synchronizer

This block produces the reset for one clock domain. It takes three reset sources: an asynchronous chip-wide reset, a clock-good flag (for example a lock flag from a clock generator), and a reset request raised by logic inside the domain. From these it drives one active-low reset for the flops downstream. The output enters reset at once through an asynchronous clear. That clear needs no clock edge, so reset still takes effect while the clock is stopped or held low.

The output leaves reset only on a rising clock edge. This keeps every downstream flop leaving reset in the same cycle. Release also waits until a short run of good clock edges has passed with every condition met, so logic that treats the output as a synchronous reset sees real clocks before it starts. The release term shifted through the chain is the AND of the clock-good flag and a reset-done flag. The internal request is captured in a flop before it reaches the clear path, so a combinational glitch on it cannot pulse the clear.

Top module: `rst_qual_sync`

## Requirements
- R1: While `glob_rst_n` is low, `rst_out_n` is low. It goes low as soon as `glob_rst_n` falls, with no clock edge needed, including while the clock is stopped.
- R2: When `clk_valid` falls, `rst_out_n` goes low at once, with no clock edge needed.
- R3: Take the moment all release conditions become true between two edges: `glob_rst_n` high, `clk_valid` high, `reset_done` high, and no registered request. From that moment, `rst_out_n` rises on exactly the STAGES-th following rising edge of `clk` and not before. STAGES has a default of 3 and a minimum of 2; any value below 2 fails elaboration.
- R4: `rst_out_n` rises only on a rising edge of `clk`. With the clock stopped, it stays low however long the conditions have been met.
- R5: While `clk_valid` is low, `rst_out_n` stays low over any number of clock edges.
- R6: If `local_req` is sampled high at a rising edge, `rst_out_n` is low right after that edge and stays low while `local_req` keeps being sampled high. A pulse on `local_req` that starts and ends between two edges has no effect on `rst_out_n`.
- R7: Take the first rising edge that samples `local_req` low after a request. `rst_out_n` rises on the STAGES-th rising edge after that edge.
- R8: If `reset_done` falls while the output is released, `rst_out_n` stays high for STAGES-1 more edges and goes low on the STAGES-th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the domain being reset; may stop |
| glob_rst_n | input | 1 | Chip-wide asynchronous reset, active low |
| clk_valid | input | 1 | High when the clock is good (for example, generator locked) |
| reset_done | input | 1 | High when upstream reset sequencing has finished |
| local_req | input | 1 | Reset request from logic in the domain, active high, sampled on `clk` |
| rst_out_n | output | 1 | Reset for the domain, active low, released on a clock edge |

## Verification
Every cycle, the assertions check four things. The output is low whenever the global reset or the clock-good flag is low. A sampled local request forces reset on the next cycle. Any rise of the output follows a cycle in which the clear path was released. A full run of STAGES qualified edges always leaves the output high. Some behaviour only the bench scenarios can show, because it happens with no edge to sample on: assertion while the clock is stopped, and the absence of release over a long stopped period. The bench scenarios also pin down the exact release edge after each kind of cause, the delayed drop after `reset_done` falls, and the harmless glitch on the request input. A sweep over all sixteen input combinations then checks both the immediate response and the settled response.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int STAGES_DEFAULT = 3;
    localparam int STAGES_MIN     = 2;

    // Snapshot of every reset source feeding the synchronizer.
    typedef struct packed {
        logic glob_n;   // chip-wide reset, active low
        logic clk_ok;   // clock is good
        logic done;     // upstream sequencing finished
        logic req_q;    // registered local request, active high
    } rsq_src_t;

    // Asynchronous clear of the chain, active low: any hard cause forces reset.
    function automatic logic rsq_clear_n(input rsq_src_t s);
        return s.glob_n & s.clk_ok & ~s.req_q;
    endfunction

    // Value shifted into the chain: release is allowed only with a good clock
    // and finished sequencing.
    function automatic logic rsq_qualify(input rsq_src_t s);
        return s.clk_ok & s.done;
    endfunction

endpackage

// File: rtl/rsq_req_reg.sv
module rsq_req_reg (
    input  logic clk,
    input  logic glob_rst_n,
    input  logic req_in,
    output logic req_q
);

    // Captures the local request on the clock so that combinational hazards
    // on req_in never reach the asynchronous clear of the chain.
    always_ff @(posedge clk or negedge glob_rst_n) begin
        if (!glob_rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_in;
        end
    end

endmodule

// File: rtl/rsq_stage_chain.sv
module rsq_stage_chain #(
    parameter int STAGES = rsq_pkg::STAGES_DEFAULT
) (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES < rsq_pkg::STAGES_MIN) begin : g_bad_depth
            $error("rsq_stage_chain: STAGES must be at least 2");
        end
    endgenerate

    logic [STAGES-1:0] st;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st <= '0;
        end else begin
            st <= {st[STAGES-2:0], d};
        end
    end

    assign q = st[STAGES-1];

    AST_CHAIN_CLEARED: assert property (@(posedge clk)
        !clr_n |-> (st == '0)); // R2

endmodule

// File: rtl/rst_qual_sync.sv
module rst_qual_sync #(
    parameter int STAGES = rsq_pkg::STAGES_DEFAULT
) (
    input  logic clk,
    input  logic glob_rst_n,
    input  logic clk_valid,
    input  logic reset_done,
    input  logic local_req,
    output logic rst_out_n
);
    import rsq_pkg::*;

    localparam int CW = $clog2(STAGES + 1);

    logic     req_q;
    rsq_src_t src;
    logic     clr_n;
    logic     qual;

    rsq_req_reg u_req (
        .clk        (clk),
        .glob_rst_n (glob_rst_n),
        .req_in     (local_req),
        .req_q      (req_q)
    );

    always_comb begin
        src.glob_n = glob_rst_n;
        src.clk_ok = clk_valid;
        src.done   = reset_done;
        src.req_q  = req_q;
    end

    assign clr_n = rsq_clear_n(src);
    assign qual  = rsq_qualify(src);

    rsq_stage_chain #(.STAGES(STAGES)) u_chain (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (qual),
        .q     (rst_out_n)
    );

    // Run length of qualified edges, used only to check the release window.
    logic [CW-1:0] ok_run;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            ok_run <= '0;
        end else if (!qual) begin
            ok_run <= '0;
        end else if (ok_run != CW'(STAGES)) begin
            ok_run <= ok_run + 1'b1;
        end
    end

    AST_GLOBAL_HOLDS: assert property (@(posedge clk)
        !glob_rst_n |-> !rst_out_n); // R1

    AST_CLKVALID_HOLDS: assert property (@(posedge clk) disable iff (!glob_rst_n)
        !clk_valid |-> !rst_out_n); // R5

    AST_FULL_RELEASE: assert property (@(posedge clk) disable iff (!glob_rst_n)
        (ok_run == CW'(STAGES)) |-> rst_out_n); // R3

    AST_EDGE_RELEASE: assert property (@(posedge clk) disable iff (!glob_rst_n)
        $rose(rst_out_n) |-> $past(clk_valid && !req_q)); // R4

    AST_REQ_TAKES_HOLD: assert property (@(posedge clk) disable iff (!glob_rst_n)
        local_req |=> !rst_out_n); // R6

endmodule

// File: tb/rst_qual_sync_tb_top.sv
`timescale 1ns/1ps
module rst_qual_sync_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int STAGES     = 3;

    logic clk = 1'b0;
    logic clk_en = 1'b1;
    logic glob_rst_n = 1'b0;
    logic clk_valid = 1'b1;
    logic reset_done = 1'b1;
    logic local_req = 1'b0;
    logic rst_out_n;

    int n_chk = 0;
    int n_fail = 0;

    rst_qual_sync #(.STAGES(STAGES)) dut_i (
        .clk        (clk),
        .glob_rst_n (glob_rst_n),
        .clk_valid  (clk_valid),
        .reset_done (reset_done),
        .local_req  (local_req),
        .rst_out_n  (rst_out_n)
    );

    always begin
        #(CLK_PERIOD/2);
        if (clk_en) clk = ~clk;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rst_out_n=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic stop_clk();
        @(negedge clk);
        #1;
        clk_en = 1'b0;
    endtask

    task automatic release_check(input string tag);
        for (int k = 1; k <= STAGES; k++) begin
            step();
            chk(tag, rst_out_n, logic'(k == STAGES));
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // Reset state: R1
        repeat (3) step();
        chk("R1 reset state", rst_out_n, 1'b0);

        // Release from global reset: R3
        glob_rst_n = 1'b1;
        release_check("R3 global release");
        step();
        chk("R3 stays released", rst_out_n, 1'b1);

        // Global reset with the clock stopped: R1, then no release: R4
        stop_clk();
        glob_rst_n = 1'b0;
        #1 chk("R1 stopped clock", rst_out_n, 1'b0);
        #40 chk("R1 held", rst_out_n, 1'b0);
        glob_rst_n = 1'b1;
        #50 chk("R4 no edge no release", rst_out_n, 1'b0);
        clk_en = 1'b1;
        release_check("R4 release after restart");

        // Clock-good drop with the clock stopped: R2, held low: R5
        stop_clk();
        clk_valid = 1'b0;
        #1 chk("R2 immediate", rst_out_n, 1'b0);
        clk_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            step();
            chk("R5 held while invalid", rst_out_n, 1'b0);
        end
        clk_valid = 1'b1;
        release_check("R3 clock-good release");

        // Glitch on the local request between edges: R6
        step();
        local_req = 1'b1;
        #2 local_req = 1'b0;
        for (int k = 0; k <= STAGES; k++) begin
            step();
            chk("R6 glitch ignored", rst_out_n, 1'b1);
        end

        // Sampled request: R6, release after it: R7
        local_req = 1'b1;
        step();
        chk("R6 request asserts", rst_out_n, 1'b0);
        step();
        chk("R6 request held", rst_out_n, 1'b0);
        local_req = 1'b0;
        for (int k = 1; k <= STAGES + 1; k++) begin
            step();
            chk("R7 request release", rst_out_n, logic'(k == STAGES + 1));
        end

        // reset_done drop: R8
        reset_done = 1'b0;
        for (int k = 1; k <= STAGES; k++) begin
            step();
            chk("R8 delayed drop", rst_out_n, logic'(k < STAGES));
        end
        repeat (3) begin
            step();
            chk("R8 held low", rst_out_n, 1'b0);
        end
        reset_done = 1'b1;
        release_check("R8 release");

        // Sweep over all source combinations
        for (int c = 0; c < 16; c++) begin
            logic g, v, d, r;
            g = c[0]; v = c[1]; d = c[2]; r = c[3];
            glob_rst_n = g; clk_valid = v; reset_done = d; local_req = r;
            #1 chk("R1/R2 sweep immediate", rst_out_n, g & v);
            repeat (STAGES + 2) step();
            chk("R5/R6 sweep settled", rst_out_n, g & v & d & ~r);
            glob_rst_n = 1'b1; clk_valid = 1'b1; reset_done = 1'b1; local_req = 1'b0;
            repeat (STAGES + 2) step();
            chk("R3 sweep recovered", rst_out_n, 1'b1);
        end

        summary();
        $finish;
    end

endmodule